// File: doc/BRIEF.md
# External Memory Bus Bridge for a Host Soft Processor

This block sits on the byte-wide internal I/O port of a small host soft processor. It turns register writes from that processor into external memory cycles of a classic 8-bit microcontroller style. The host loads a 16-bit address, and a write byte when it needs one, then writes a command byte. The bridge then runs one code fetch, one data read or one data write on the external side. Code memory and data memory each have their own address and data pins, so no demultiplexing latch is needed outside the block.

Every external cycle opens with a one-clock bus-start pulse. A single strobe, exactly one clock wide, fires in that same cycle: the program-store enable for code reads, the read strobe for data reads, or the write strobe for data writes. A hold input stretches the cycle with wait states for slow memory. With hold tied low, every access ends on the clock edge right after the strobe. The host polls a busy flag in the status register; that flag is the only flow control. The host register port is a plain register interface, not a valid/ready stream. A command written while busy is dropped and sets a sticky error flag.

Top module: `xmb_bridge`

## Requirements
- R1: An active-high synchronous reset clears busy and the error flag, zeroes the address and write-data registers (both address buses read 0), and holds bus-start and all three strobes low.
- R2: At I/O offsets from BASE, offset 0 is address low byte, 1 address high byte, 2 write data, 3 captured read data (read only), 4 command, 5 status (bit 0 busy, bit 1 sticky error). Offsets 0 to 2 read back what was written. The code address bus and the data address bus both equal {high, low}, and the data write bus equals the write-data register.
- R3: Writing command 0x01 while idle makes bus-start and the program-store enable high together for exactly the one clock after the write edge. Read and write strobes stay low.
- R4: Command 0x02 does the same with the read strobe. Program-store enable and write strobe stay low.
- R5: Command 0x03 does the same with the write strobe. The data address and data write buses carry the loaded values during the strobe cycle.
- R6: Busy reads 1 from the write edge of an accepted command. With hold low at the edge ending the bus-start cycle, busy is 0 right after that edge. A read captures the addressed memory byte (code or data bus) at that edge into offset 3.
- R7: Each edge that sees hold high, from the edge ending the bus-start cycle on, adds one wait cycle. During wait cycles busy stays 1 and no strobe or bus-start repeats. Read data is captured only on the first edge with hold low.
- R8: A command written while busy starts no cycle and sets status bit 1. That bit stays set until reset.
- R9: Writes to offsets 0 to 2 while busy are ignored, so the address buses stay stable for the whole cycle.
- R10: A command byte other than 0x01, 0x02 or 0x03 written while idle starts no cycle and leaves busy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 8 | Host I/O address |
| io_wr | input | 1 | Host I/O write enable |
| io_wdata | input | 8 | Host I/O write data |
| io_rdata | output | 8 | Host I/O read data (combinational on io_addr) |
| code_addr | output | 16 | Program memory address |
| code_rdata | input | 8 | Program memory read data |
| psen | output | 1 | Program-store enable strobe, one clock |
| data_addr | output | 16 | Data memory address |
| data_rdata | input | 8 | Data memory read data |
| data_wdata | output | 8 | Data memory write data |
| rd_strb | output | 1 | Data read strobe, one clock |
| wr_strb | output | 1 | Data write strobe, one clock |
| bus_start | output | 1 | Start-of-cycle pulse |
| hold | input | 1 | Wait-state request |

## Verification
Inputs change on falling edges. Let E be the rising edge that takes the command write. Bus-start and the strobe are checked in the half cycle after E, and busy and captured data are checked one edge later when no wait is asked. Each wait cycle moves completion one edge further. The bench checks busy and the quiet strobes at every wait cycle and the captured byte only after the first edge with hold low. While hold is high the memory model returns a decoy byte, so capture on a wrong edge shows up as a mismatch.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int OFS_W  = 8;
  localparam logic [OFS_W-1:0] OFS_ALO  = 8'd0;
  localparam logic [OFS_W-1:0] OFS_AHI  = 8'd1;
  localparam logic [OFS_W-1:0] OFS_WD   = 8'd2;
  localparam logic [OFS_W-1:0] OFS_RD   = 8'd3;
  localparam logic [OFS_W-1:0] OFS_CMD  = 8'd4;
  localparam logic [OFS_W-1:0] OFS_STAT = 8'd5;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_CODE = 2'd1,
    K_DRD  = 2'd2,
    K_DWR  = 2'd3
  } kind_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_START = 2'd1,
    S_WAIT  = 2'd2
  } state_t;
endpackage

// File: rtl/xmb_regs.sv
module xmb_regs
  import xmb_pkg::*;
#(
  parameter logic [OFS_W-1:0] BASE = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  io_addr,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] rdata_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              go,
  output kind_t             go_kind
);
  localparam int HALF = ADDR_W / 2;

  logic [OFS_W-1:0] off;
  logic             err_q;
  logic             cmd_hit;
  logic             cmd_valid;

  assign off       = io_addr - BASE;
  assign cmd_hit   = io_wr && (off == OFS_CMD);
  assign cmd_valid = (io_wdata == 8'h01) || (io_wdata == 8'h02) || (io_wdata == 8'h03);
  assign go        = cmd_hit && !busy && cmd_valid;
  assign go_kind   = cmd_valid ? kind_t'(io_wdata[1:0]) : K_NONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (io_wr && !busy) begin
        if (off == OFS_ALO) addr_q[HALF-1:0]      <= io_wdata;
        if (off == OFS_AHI) addr_q[ADDR_W-1:HALF] <= io_wdata;
        if (off == OFS_WD)  wdata_q               <= io_wdata;
      end
      if (cmd_hit && busy) err_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (off)
      OFS_ALO:  io_rdata = addr_q[HALF-1:0];
      OFS_AHI:  io_rdata = addr_q[ADDR_W-1:HALF];
      OFS_WD:   io_rdata = wdata_q;
      OFS_RD:   io_rdata = rdata_q;
      OFS_STAT: io_rdata = {{(DATA_W-2){1'b0}}, err_q, busy};
      default:  io_rdata = '0;
    endcase
  end

  // R8: a command that collides with a running cycle leaves the error flag set
  a_r8_err_on_collide: assert property (@(posedge clk) disable iff (rst)
    cmd_hit && busy |=> err_q);

  // R8: the error flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  // R9: address held while a cycle runs
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(addr_q));
endmodule

// File: rtl/xmb_seq.sv
module xmb_seq
  import xmb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  go,
  input  kind_t go_kind,
  input  logic  hold,
  output logic  busy,
  output logic  bus_start,
  output logic  psen,
  output logic  rd_strb,
  output logic  wr_strb,
  output logic  done,
  output kind_t kind_q
);
  state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      kind_q <= K_NONE;
    end else begin
      unique case (state)
        S_IDLE: if (go) begin
          state  <= S_START;
          kind_q <= go_kind;
        end
        S_START, S_WAIT: state <= hold ? S_WAIT : S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign bus_start = (state == S_START);
  assign psen      = bus_start && (kind_q == K_CODE);
  assign rd_strb   = bus_start && (kind_q == K_DRD);
  assign wr_strb   = bus_start && (kind_q == K_DWR);
  assign done      = busy && !hold;

  // R3: program-store enable lasts one clock
  a_r3_psen_single: assert property (@(posedge clk) disable iff (rst)
    psen |=> !psen);
  // R4: read strobe lasts one clock
  a_r4_rd_single: assert property (@(posedge clk) disable iff (rst)
    rd_strb |=> !rd_strb);
  // R5: write strobe lasts one clock
  a_r5_wr_single: assert property (@(posedge clk) disable iff (rst)
    wr_strb |=> !wr_strb);
  // R3: never two strobes at once
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({psen, rd_strb, wr_strb}));
  // R6: no hold after bus start means the cycle is over next clock
  a_r6_zero_wait: assert property (@(posedge clk) disable iff (rst)
    bus_start && !hold |=> !busy);
  // R7: hold keeps the cycle open and bus start does not repeat
  a_r7_hold_busy: assert property (@(posedge clk) disable iff (rst)
    busy && hold |=> busy && !bus_start);
endmodule

// File: rtl/xmb_capture.sv
module xmb_capture
  import xmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  kind_t             kind_q,
  input  logic [DATA_W-1:0] code_rdata,
  input  logic [DATA_W-1:0] data_rdata,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (done) begin
      if (kind_q == K_CODE)     rdata_q <= code_rdata;
      else if (kind_q == K_DRD) rdata_q <= data_rdata;
    end
  end

  // R7: the captured byte only changes on a completing edge
  a_r7_capture_edge: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(rdata_q));
endmodule

// File: rtl/xmb_bridge.sv
module xmb_bridge
  import xmb_pkg::*;
#(
  parameter logic [7:0] BASE = 8'h00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  io_addr,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic [15:0] code_addr,
  input  logic [7:0]  code_rdata,
  output logic        psen,
  output logic [15:0] data_addr,
  input  logic [7:0]  data_rdata,
  output logic [7:0]  data_wdata,
  output logic        rd_strb,
  output logic        wr_strb,
  output logic        bus_start,
  input  logic        hold
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              busy;
  logic              go;
  logic              done;
  kind_t             go_kind;
  kind_t             kind_q;

  xmb_regs #(.BASE(BASE)) u_regs (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .busy(busy),
    .rdata_q(rdata_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .go(go), .go_kind(go_kind)
  );

  xmb_seq u_seq (
    .clk(clk), .rst(rst), .go(go), .go_kind(go_kind), .hold(hold),
    .busy(busy), .bus_start(bus_start), .psen(psen), .rd_strb(rd_strb),
    .wr_strb(wr_strb), .done(done), .kind_q(kind_q)
  );

  xmb_capture u_cap (
    .clk(clk), .rst(rst), .done(done), .kind_q(kind_q),
    .code_rdata(code_rdata), .data_rdata(data_rdata), .rdata_q(rdata_q)
  );

  assign code_addr  = addr_q;
  assign data_addr  = addr_q;
  assign data_wdata = wdata_q;
endmodule

// File: tb/tb_xmb_bridge.sv
module tb_xmb_bridge;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  io_addr = 8'd0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = 8'd0;
  logic [7:0]  io_rdata;
  logic [15:0] code_addr, data_addr;
  logic [7:0]  code_rdata, data_rdata, data_wdata;
  logic        psen, rd_strb, wr_strb, bus_start;
  logic        hold = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [7:0] mem_code(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] mem_data(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h33;
  endfunction

  assign code_rdata = hold ? 8'hEE : mem_code(code_addr);
  assign data_rdata = hold ? 8'hDD : mem_data(data_addr);

  xmb_bridge dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .code_addr(code_addr),
    .code_rdata(code_rdata), .psen(psen), .data_addr(data_addr),
    .data_rdata(data_rdata), .data_wdata(data_wdata), .rd_strb(rd_strb),
    .wr_strb(wr_strb), .bus_start(bus_start), .hold(hold)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  function automatic logic [7:0] rd_reg(input logic [7:0] a);
    io_addr = a;
    return io_rdata;
  endfunction

  task automatic peek(input logic [7:0] a, output logic [7:0] v);
    io_addr = a;
    #1;
    v = io_rdata;
  endtask

  // one full access; nwait wait cycles requested through hold
  task automatic access(input logic [7:0] cmd, input logic [15:0] a,
                        input logic [7:0] wd, input int nwait);
    logic [7:0] v;
    logic [7:0] prev_rd;
    io_write(8'd0, a[7:0]);
    io_write(8'd1, a[15:8]);
    io_write(8'd2, wd);
    peek(8'd3, prev_rd);
    io_write(8'd4, cmd);
    hold = (nwait > 0);
    peek(8'd5, v);
    check("R6 busy in start cycle", {31'd0, v[0]}, 1);
    check("R3 R4 R5 bus_start", {31'd0, bus_start}, 1);
    check("R3 psen", {31'd0, psen}, {31'd0, cmd == 8'h01});
    check("R4 rd_strb", {31'd0, rd_strb}, {31'd0, cmd == 8'h02});
    check("R5 wr_strb", {31'd0, wr_strb}, {31'd0, cmd == 8'h03});
    check("R2 code_addr", {16'd0, code_addr}, {16'd0, a});
    check("R5 data_addr", {16'd0, data_addr}, {16'd0, a});
    if (cmd == 8'h03) check("R5 data_wdata", {24'd0, data_wdata}, {24'd0, wd});
    for (int i = 0; i < nwait; i++) begin
      @(negedge clk);
      hold = (i < nwait - 1);
      peek(8'd5, v);
      check("R7 busy in wait", {31'd0, v[0]}, 1);
      check("R7 no strobe repeat", {28'd0, bus_start, psen, rd_strb, wr_strb}, 0);
      check("R9 address stable", {16'd0, code_addr}, {16'd0, a});
      peek(8'd3, v);
      check("R7 no early capture", {24'd0, v}, {24'd0, prev_rd});
    end
    @(negedge clk);
    peek(8'd5, v);
    check("R6 busy cleared", {31'd0, v[0]}, 0);
    peek(8'd3, v);
    if (cmd == 8'h01) check("R6 code capture", {24'd0, v}, {24'd0, mem_code(a)});
    else if (cmd == 8'h02) check("R6 data capture", {24'd0, v}, {24'd0, mem_data(a)});
    else check("R6 write keeps rdata", {24'd0, v}, {24'd0, prev_rd});
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 strobes low", {28'd0, bus_start, psen, rd_strb, wr_strb}, 0);
    check("R1 addr zero", {code_addr, data_addr}, 0);
    peek(8'd5, v);
    check("R1 status zero", {24'd0, v}, 0);

    // R2 register readback
    io_write(8'd0, 8'h34);
    io_write(8'd1, 8'h12);
    io_write(8'd2, 8'hA5);
    peek(8'd0, v); check("R2 addr lo", {24'd0, v}, 32'h34);
    peek(8'd1, v); check("R2 addr hi", {24'd0, v}, 32'h12);
    peek(8'd2, v); check("R2 wdata", {24'd0, v}, 32'hA5);
    check("R2 buses", {data_addr, 8'd0, data_wdata}, {16'h1234, 8'd0, 8'hA5});

    // directed: zero-wait and waited accesses of each kind
    access(8'h01, 16'hBEEF, 8'h00, 0);
    access(8'h02, 16'h0102, 8'h00, 0);
    access(8'h03, 16'hFFFF, 8'h77, 0);
    access(8'h01, 16'h0000, 8'h00, 3);
    access(8'h02, 16'h8001, 8'h00, 1);

    // R10 invalid command bytes
    io_write(8'd4, 8'h00);
    #1;
    check("R10 no cycle 0x00", {27'd0, bus_start, psen, rd_strb, wr_strb, rd_reg(8'd5)[0]}, 0);
    io_write(8'd4, 8'h81);
    #1;
    check("R10 no cycle 0x81", {27'd0, bus_start, psen, rd_strb, wr_strb, rd_reg(8'd5)[0]}, 0);

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [7:0] c;
      c = 8'($urandom_range(1, 3));
      access(c, 16'($urandom), 8'($urandom), int'($urandom_range(0, 4)));
    end

    // R8 R9 collision while busy
    io_write(8'd0, 8'h10);
    io_write(8'd1, 8'h20);
    io_write(8'd4, 8'h01);
    hold = 1'b1;
    io_write(8'd0, 8'hFF);
    io_write(8'd4, 8'h03);
    #1;
    check("R8 no new strobe", {28'd0, bus_start, psen, rd_strb, wr_strb}, 0);
    peek(8'd5, v); check("R8 busy and error", {24'd0, v}, 32'h3);
    peek(8'd0, v); check("R9 addr lo ignored", {24'd0, v}, 32'h10);
    hold = 1'b0;
    @(negedge clk);
    peek(8'd5, v); check("R8 error sticky", {24'd0, v}, 32'h2);
    peek(8'd3, v); check("R7 capture after collision", {24'd0, v}, {24'd0, mem_code(16'h2010)});
    @(negedge clk);
    #1;
    check("R8 no late write", {31'd0, wr_strb}, 0);

    // R1 reset clears error and address
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    peek(8'd5, v); check("R1 error cleared", {24'd0, v}, 0);
    check("R1 addr cleared", {16'd0, code_addr}, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule